// File: doc/BRIEF.md
# Message-Signalled Interrupt Write Decoder

This block sits on the inbound side of a message-signalled interrupt path. Each write arrives as a 64-bit address and a 32-bit data word under a valid strobe. The block compares the top 44 address bits with a programmable translation base. It then decodes the lower address bits to pick a delivery target: up to four local interrupt-controller clusters, or a single I/O interrupt controller. The interrupt number to set, a wake request and a function hint also come from these bits.

Each accepted write turns into single-cycle set pulses. These pulses appear one clock after the write. They carry a 10-bit shared-interrupt index and a sideband hint bit. A write that fails any check is dropped, and a sticky error flag is raised. The data word plays no part in delivery. The write port is always ready, so any write that is valid on a clock edge is decoded on that edge.

Top module: `msix_decode_top`

## Requirements
- R1: After reset, localSet, ioSet, wakeEvent and errSticky are all zero and wrReady is 1.
- R2: A write is accepted only when wrAddr[63:20] equals baseAddr. On a mismatch, no pulse is produced and errSticky is set one cycle later.
- R3: Target field wrAddr[18:17]=0 delivers to local clusters. In the next cycle, localSet[c] pulses for one cycle for each cluster c selected by the mask. The mask maps address bit 16 to cluster 0, bit 15 to cluster 1, bit 14 to cluster 2 and bit 13 to cluster 3.
- R4: Target field value 1 pulses ioSet for one cycle in the next cycle and leaves localSet at zero, whatever the mask bits hold.
- R5: Target field values 2 and 3 are reserved. Such a write produces no pulse and sets errSticky.
- R6: wrAddr[12:3] appears on spiIndex together with the pulse. For a local target, only indices 0 to 249 are accepted; index 250 and above produces no pulse and sets errSticky. The I/O target accepts indices up to 1023.
- R7: When wrAddr[19] is set on an accepted write, wakeEvent pulses for one cycle in the next cycle, for each cluster selected by the mask (same bit mapping as R3).
- R8: wrAddr[2] appears on funcHint alongside the pulse.
- R9: If wrAddr[1:0] is nonzero, the write produces no pulse and sets errSticky.
- R10: A local-target write with an all-zero cluster mask produces no pulse and sets errSticky.
- R11: The data word has no effect on any output.
- R12: errSticky stays set until reset, and later valid writes are still delivered. A cycle with wrValid low produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | 44 | Programmed translation base, compared with wrAddr[63:20] |
| wrValid | input | 1 | Write valid strobe |
| wrReady | output | 1 | Write ready, always 1 |
| wrAddr | input | 64 | Message address carrying all decode fields |
| wrData | input | 32 | Message data word, ignored |
| localSet | output | 4 | One-cycle set pulse per local cluster |
| ioSet | output | 1 | One-cycle set pulse to the I/O controller |
| wakeEvent | output | 4 | One-cycle wake pulse per cluster |
| spiIndex | output | 10 | Interrupt index of the last accepted write |
| funcHint | output | 1 | Function hint of the last accepted write |
| errSticky | output | 1 | Set by any rejected write, cleared only by reset |

## Verification
Each error condition sets the same sticky flag. Once that flag is up, it hides whether a later bad write was seen at all. The stimulus therefore resets the block before each error case and checks the flag starting from zero. After an error it sends a good write, to show that delivery still works. The index limit of 249 is checked from both sides with a local target and a non-empty mask. Back-to-back writes to different targets show that each pulse lasts exactly one cycle and is not stretched by the write that follows.

// File: rtl/msix_dec_pkg.sv
package msix_dec_pkg;
  localparam int ADDR_W       = 64;
  localparam int DATA_W       = 32;
  localparam int BASE_LSB     = 20;
  localparam int BASE_W       = ADDR_W - BASE_LSB;
  localparam int WAKE_BIT     = 19;
  localparam int TGT_LSB      = 17;
  localparam int TGT_W        = 2;
  localparam int NUM_CLUSTERS = 4;
  localparam int MASK_MSB     = 16;
  localparam int MASK_LSB     = MASK_MSB - NUM_CLUSTERS + 1;
  localparam int SPI_W        = 10;
  localparam int IDX_LSB      = 3;
  localparam int HINT_BIT     = 2;
  localparam int LOW_W        = 2;
  localparam int LOCAL_LIMIT  = 250;

  typedef enum logic [TGT_W-1:0] {
    TGT_LOCAL = 2'd0,
    TGT_IO    = 2'd1,
    TGT_RSV2  = 2'd2,
    TGT_RSV3  = 2'd3
  } tgtId_e;

  typedef struct packed {
    logic capture;
    logic toLocal;
    logic toIo;
    logic wake;
    logic flagErr;
  } decStrobe_t;
endpackage

// File: rtl/msix_dec_ctrl.sv
module msix_dec_ctrl
  import msix_dec_pkg::*;
(
  input  logic                    wrFire,
  input  logic [BASE_W-1:0]       baseAddr,
  input  logic [BASE_W-1:0]       baseField,
  input  logic                    wakeBit,
  input  logic [TGT_W-1:0]        tgtField,
  input  logic [NUM_CLUSTERS-1:0] maskField,
  input  logic [SPI_W-1:0]        idxField,
  input  logic [LOW_W-1:0]        lowField,
  output decStrobe_t              strobes
);
  tgtId_e tgtId;
  logic baseHit, lowClean, isLocal, isIo, idxInRange, maskAny, goodLocal, accept;

  always_comb begin
    tgtId      = tgtId_e'(tgtField);
    baseHit    = (baseField == baseAddr);
    lowClean   = (lowField == '0);
    isLocal    = (tgtId == TGT_LOCAL);
    isIo       = (tgtId == TGT_IO);
    idxInRange = ({22'd0, idxField} < LOCAL_LIMIT);
    maskAny    = |maskField;
    goodLocal  = isLocal && maskAny && idxInRange;
    accept     = baseHit && lowClean && (goodLocal || isIo);

    strobes.capture = wrFire && accept;
    strobes.toLocal = wrFire && accept && isLocal;
    strobes.toIo    = wrFire && accept && isIo;
    strobes.wake    = wrFire && accept && wakeBit;
    strobes.flagErr = wrFire && !accept;
  end

  // R5 / R9: a rejected write never captures
  always_comb begin
    if (strobes.capture) begin
      a_r9_capture_clean: assert (lowClean);
    end
  end
endmodule

// File: rtl/msix_dec_dpath.sv
module msix_dec_dpath
  import msix_dec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  decStrobe_t              strobes,
  input  logic [NUM_CLUSTERS-1:0] maskField,
  input  logic [SPI_W-1:0]        idxField,
  input  logic                    hintBit,
  output logic [NUM_CLUSTERS-1:0] localSet,
  output logic                    ioSet,
  output logic [NUM_CLUSTERS-1:0] wakeEvent,
  output logic [SPI_W-1:0]        spiIndex,
  output logic                    funcHint,
  output logic                    errSticky
);
  logic [NUM_CLUSTERS-1:0] clusterSel;

  // address mask is numbered from its top bit: top bit selects cluster 0
  for (genvar c = 0; c < NUM_CLUSTERS; c++) begin : gClusterMap
    assign clusterSel[c] = maskField[NUM_CLUSTERS-1-c];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      localSet  <= '0;
      ioSet     <= 1'b0;
      wakeEvent <= '0;
      spiIndex  <= '0;
      funcHint  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      localSet  <= strobes.toLocal ? clusterSel : '0;
      ioSet     <= strobes.toIo;
      wakeEvent <= strobes.wake ? clusterSel : '0;
      if (strobes.capture) begin
        spiIndex <= idxField;
        funcHint <= hintBit;
      end
      if (strobes.flagErr) errSticky <= 1'b1;
    end
  end

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);

  a_r4_io_excludes_local: assert property (@(posedge clk) disable iff (!rstN)
    ioSet |-> (localSet == '0));

  a_r6_local_index_range: assert property (@(posedge clk) disable iff (!rstN)
    (|localSet) |-> ({22'd0, spiIndex} < LOCAL_LIMIT));

  a_r3_pulse_from_strobe: assert property (@(posedge clk) disable iff (!rstN)
    strobes.toLocal && (|maskField) |=> (|localSet));
endmodule

// File: rtl/msix_decode_top.sv
module msix_decode_top
  import msix_dec_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [BASE_W-1:0]       baseAddr,
  input  logic                    wrValid,
  output logic                    wrReady,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  output logic [NUM_CLUSTERS-1:0] localSet,
  output logic                    ioSet,
  output logic [NUM_CLUSTERS-1:0] wakeEvent,
  output logic [SPI_W-1:0]        spiIndex,
  output logic                    funcHint,
  output logic                    errSticky
);
  decStrobe_t strobes;
  logic wrFire;
  logic unusedData;

  assign wrReady    = 1'b1;
  assign wrFire     = wrValid && wrReady;
  assign unusedData = ^wrData;

  msix_dec_ctrl uCtrl (
    .wrFire    (wrFire),
    .baseAddr  (baseAddr),
    .baseField (wrAddr[ADDR_W-1:BASE_LSB]),
    .wakeBit   (wrAddr[WAKE_BIT]),
    .tgtField  (wrAddr[TGT_LSB+TGT_W-1:TGT_LSB]),
    .maskField (wrAddr[MASK_MSB:MASK_LSB]),
    .idxField  (wrAddr[IDX_LSB+SPI_W-1:IDX_LSB]),
    .lowField  (wrAddr[LOW_W-1:0]),
    .strobes   (strobes)
  );

  msix_dec_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .maskField (wrAddr[MASK_MSB:MASK_LSB]),
    .idxField  (wrAddr[IDX_LSB+SPI_W-1:IDX_LSB]),
    .hintBit   (wrAddr[HINT_BIT]),
    .localSet  (localSet),
    .ioSet     (ioSet),
    .wakeEvent (wakeEvent),
    .spiIndex  (spiIndex),
    .funcHint  (funcHint),
    .errSticky (errSticky)
  );

  a_r2_mismatch_drops: assert property (@(posedge clk) disable iff (!rstN)
    (wrFire && (wrAddr[ADDR_W-1:BASE_LSB] != baseAddr))
      |=> ((localSet == '0) && !ioSet && errSticky));
endmodule

// File: tb/tb_msix_decode_top.sv
module tb_msix_decode_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [43:0] baseAddr;
  logic wrValid = 1'b0;
  logic wrReady;
  logic [63:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [3:0] localSet, wakeEvent;
  logic ioSet, funcHint, errSticky;
  logic [9:0] spiIndex;

  int nRun = 0;
  int nFail = 0;

  logic [3:0] expL, expW;
  logic expIo, expErr, expH;
  logic [9:0] expI;

  always #4 clk = ~clk;

  msix_decode_top dut (
    .clk(clk), .rstN(rstN), .baseAddr(baseAddr), .wrValid(wrValid),
    .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .localSet(localSet), .ioSet(ioSet), .wakeEvent(wakeEvent),
    .spiIndex(spiIndex), .funcHint(funcHint), .errSticky(errSticky)
  );

  function automatic logic [63:0] mk(input logic [43:0] b, input logic wk,
      input logic [1:0] tg, input logic [3:0] m, input int idx,
      input logic h, input logic [1:0] lo);
    logic [9:0] ix;
    ix = idx[9:0];
    return {b, wk, tg, m, ix, h, lo};
  endfunction

  task automatic checkNow(input string tag);
    nRun++;
    if (localSet !== expL || ioSet !== expIo || wakeEvent !== expW || errSticky !== expErr) begin
      nFail++;
      $display("FAIL %s: local=%b io=%b wake=%b err=%b expected local=%b io=%b wake=%b err=%b",
               tag, localSet, ioSet, wakeEvent, errSticky, expL, expIo, expW, expErr);
    end
    if (expL != 0 || expIo) begin
      nRun++;
      if (spiIndex !== expI || funcHint !== expH) begin
        nFail++;
        $display("FAIL %s: index=%0d hint=%b expected index=%0d hint=%b",
                 tag, spiIndex, funcHint, expI, expH);
      end
    end
  endtask

  task automatic step(input logic v, input logic [63:0] a, input logic [31:0] d, input string tag);
    logic ok;
    int ix;
    wrValid = v; wrAddr = a; wrData = d;
    ix = int'(a[12:3]);
    ok = v && (a[63:20] == baseAddr) && (a[1:0] == 2'b00) &&
         ((a[18:17] == 2'd1) || (a[18:17] == 2'd0 && a[16:13] != 4'd0 && ix <= 249));
    for (int c = 0; c < 4; c++) begin
      expL[c] = ok && (a[18:17] == 2'd0) && a[16-c];
      expW[c] = ok && a[19] && a[16-c];
    end
    expIo = ok && (a[18:17] == 2'd1);
    if (ok) begin expI = a[12:3]; expH = a[2]; end
    if (v && !ok) expErr = 1'b1;
    @(posedge clk); @(negedge clk);
    checkNow(tag);
    wrValid = 1'b0;
  endtask

  task automatic doReset();
    wrValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expL = '0; expW = '0; expIo = 1'b0; expErr = 1'b0;
    @(negedge clk);
    nRun++;
    if (localSet !== 4'd0 || ioSet !== 1'b0 || wakeEvent !== 4'd0 || errSticky !== 1'b0 || wrReady !== 1'b1) begin
      nFail++;
      $display("FAIL R1: local=%b io=%b wake=%b err=%b ready=%b expected all zero, ready=1",
               localSet, ioSet, wakeEvent, errSticky, wrReady);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [43:0] b;
    b = 44'hABC_1234_5678;
    baseAddr = b;
    expI = '0; expH = 1'b0;
    doReset();                                                               // R1
    step(1, mk(b, 0, 2'd0, 4'b1000, 5, 0, 2'b00), 32'h0, "R3 cluster0");
    step(1, mk(b, 0, 2'd0, 4'b0001, 17, 0, 2'b00), 32'h0, "R3 cluster3");
    step(1, mk(b, 0, 2'd0, 4'b1111, 100, 0, 2'b00), 32'h0, "R3 all clusters");
    step(0, mk(b, 0, 2'd0, 4'b1111, 100, 0, 2'b00), 32'h0, "R3 one-cycle pulse");
    step(1, mk(b, 0, 2'd1, 4'b0000, 1000, 0, 2'b00), 32'h0, "R4 io");
    step(1, mk(b, 0, 2'd1, 4'b1111, 7, 0, 2'b00), 32'h0, "R4 io ignores mask");
    step(1, mk(b, 0, 2'd0, 4'b0100, 249, 0, 2'b00), 32'h0, "R6 local index 249");
    step(1, mk(b, 0, 2'd1, 4'b0000, 1023, 0, 2'b00), 32'h0, "R6 io index 1023");
    step(1, mk(b, 1, 2'd0, 4'b0101, 12, 0, 2'b00), 32'h0, "R7 wake local");
    step(1, mk(b, 1, 2'd1, 4'b0010, 12, 0, 2'b00), 32'h0, "R7 wake io");
    step(1, mk(b, 0, 2'd0, 4'b0010, 33, 1, 2'b00), 32'h0, "R8 hint");
    step(1, mk(b, 0, 2'd0, 4'b0011, 44, 1, 2'b00), 32'hFFFF_FFFF, "R11 data ones");
    step(1, mk(b, 0, 2'd0, 4'b0011, 44, 1, 2'b00), 32'h1234_0000, "R11 data other");
    step(0, mk(b, 0, 2'd1, 4'b0000, 3, 0, 2'b00), 32'h0, "R12 valid low");
    step(1, mk(b, 0, 2'd1, 4'b0000, 3, 0, 2'b00), 32'h0, "R12 idle gap");
    step(1, mk(b, 0, 2'd0, 4'b1000, 9, 0, 2'b00), 32'h0, "R3 back-to-back");

    doReset();
    step(1, mk(b ^ 44'h800_0000_0000, 0, 2'd0, 4'b1000, 5, 0, 2'b00), 32'h0, "R2 top bit mismatch");
    step(1, mk(b, 0, 2'd0, 4'b1000, 6, 0, 2'b00), 32'h0, "R12 deliver after error");
    step(0, mk(b, 0, 2'd0, 4'b1000, 6, 0, 2'b00), 32'h0, "R12 sticky holds");
    doReset();
    step(1, mk(b ^ 44'h1, 0, 2'd1, 4'b0000, 5, 0, 2'b00), 32'h0, "R2 low bit mismatch");
    doReset();
    baseAddr = 44'h000_0000_0F00;
    step(1, mk(44'h000_0000_0F00, 0, 2'd1, 4'b0000, 77, 0, 2'b00), 32'h0, "R2 new base accepted");
    step(1, mk(b, 0, 2'd1, 4'b0000, 77, 0, 2'b00), 32'h0, "R2 old base rejected");
    baseAddr = b;
    doReset();
    step(1, mk(b, 0, 2'd2, 4'b1000, 5, 0, 2'b00), 32'h0, "R5 target 2");
    doReset();
    step(1, mk(b, 1, 2'd3, 4'b1111, 5, 0, 2'b00), 32'h0, "R5 target 3");
    doReset();
    step(1, mk(b, 0, 2'd0, 4'b1000, 5, 0, 2'b01), 32'h0, "R9 low 01");
    doReset();
    step(1, mk(b, 0, 2'd1, 4'b0000, 5, 0, 2'b10), 32'h0, "R9 low 10");
    doReset();
    step(1, mk(b, 0, 2'd0, 4'b1000, 250, 0, 2'b00), 32'h0, "R6 local index 250");
    doReset();
    step(1, mk(b, 1, 2'd0, 4'b0000, 5, 0, 2'b00), 32'h0, "R10 empty mask");
    step(1, mk(b, 0, 2'd0, 4'b0100, 0, 0, 2'b00), 32'h0, "R12 index 0 after error");

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule